// File: doc/BRIEF.md
# Template Raster Address Walker

The walker produces the memory read addresses needed to compare one stored template against an image at one placement. A template is kept as an ordered list of raster headers. Each header names the linear image index where a run of valid template pixels begins and how many pixels long the run is. The template values of all runs sit back to back in a separate value memory. A small descriptor store gives, for each template, the header memory address of its first raster, its raster count and the value memory address of its first value.

A walk begins with a start pulse, a template index and a row/column placement offset. The offset is turned into a linear displacement (row times image width plus column) and added to every raster's start index. Rasters are visited in their stored order. That order is expected to put the highest-energy rasters first, so a scoring engine that sees a poor partial score can abort the walk early. For each pixel the walker issues one image address and one template value address, flags the final pixel of the final raster, and passes over empty rasters without emitting anything. Both the descriptor store and the header memory are read combinationally, from the template index and the header address respectively.

Top module: `tmpl_raster_walker`

## Requirements
- R1: After reset the walker is idle, with o_busy and o_valid low.
- R2: A start pulse while idle reads the descriptor of i_tmpl_sel (presented on o_desc_sel) and fetches that template's raster headers from i_desc_hdr_base upward, for i_desc_rcnt rasters.
- R3: Each emitted image address equals the raster start index plus off_row × IMG_W + off_col, taken modulo 2^ADDR_W, and it increases by one for each following pixel of the same raster.
- R4: Template value addresses start at i_desc_val_base and increase by one for every emitted pixel across all rasters of the walk.
- R5: Every raster takes one header cycle (o_busy high, o_valid low), followed by one address pair per cycle for as many cycles as its length. The first header cycle is the cycle after the start edge.
- R6: A raster of length zero takes only its header cycle and emits no address.
- R7: o_last is high exactly on the final pixel of the last raster, and o_busy is low on the cycle after it. When the last raster is empty, no pixel carries o_last.
- R8: Asserting i_abort makes o_valid and o_busy low on the next cycle. An abort that arrives together with a start while idle prevents the walk.
- R9: A start pulse while a walk is in progress is ignored and does not change the remaining addresses.
- R10: A template with zero rasters leaves the walker idle after start.
- R11: Rasters are visited strictly in stored header order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Begin a walk (taken only when idle) |
| i_abort | input | 1 | Stop the current walk |
| i_tmpl_sel | input | TSEL_W | Template index |
| i_off_row | input | ROW_W | Placement row offset |
| i_off_col | input | COL_W | Placement column offset |
| o_desc_sel | output | TSEL_W | Descriptor store read index |
| i_desc_hdr_base | input | HDR_AW | First header address of the template |
| i_desc_rcnt | input | RCNT_W | Number of rasters in the template |
| i_desc_val_base | input | VAL_AW | First template value address |
| o_hdr_addr | output | HDR_AW | Header memory read address |
| i_hdr_start | input | ADDR_W | Raster start image index |
| i_hdr_len | input | LEN_W | Raster length in pixels |
| o_valid | output | 1 | Address pair valid |
| o_img_addr | output | ADDR_W | Image memory address |
| o_tval_addr | output | VAL_AW | Template value memory address |
| o_last | output | 1 | Final pixel of the walk |
| o_busy | output | 1 | Walk in progress |

## Verification
The checker watches several properties on every cycle. Valid pairs never appear outside a walk. Back-to-back valid pairs step both addresses by one. An abort clears valid on the following cycle, a last pixel ends the walk, and an idle walker with no start stays idle. Only the bench's scenarios can show the exact per-cycle schedule of header and emit cycles, the offset arithmetic including wrap, the value pointer carrying across rasters, the skipping of empty rasters, and the silent drop of a start during a walk. The bench predicts each of these from its own header tables.

// File: rtl/rw_pkg.sv
package rw_pkg;
    // walker phases
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_HDR  = 2'd1,
        WS_EMIT = 2'd2
    } walk_state_e;

    localparam int unsigned DEF_IMG_W  = 32;
    localparam int unsigned DEF_IMG_H  = 32;
    localparam int unsigned DEF_TMPL_N = 4;
    localparam int unsigned DEF_HDR_N  = 64;
    localparam int unsigned DEF_VAL_N  = 1024;
    localparam int unsigned DEF_LEN_W  = 6;
    localparam int unsigned DEF_RCNT_W = 6;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/rw_offset_lin.sv
module rw_offset_lin #(
    parameter int unsigned IMG_W  = 32,
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned COL_W  = 5,
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ROW_W-1:0]  i_row,
    input  logic [COL_W-1:0]  i_col,
    output logic [ADDR_W-1:0] o_lin
);
    localparam int unsigned SHIFT = $clog2(IMG_W);
    localparam int unsigned PW    = ADDR_W + ROW_W + SHIFT + 1;

    logic [PW-1:0] prod;

    generate
        if (rw_pkg::is_pow2(IMG_W)) begin : g_shift
            assign prod = PW'(i_row) << SHIFT;
        end else begin : g_mult
            assign prod = PW'(i_row) * PW'(IMG_W);
        end
    endgenerate

    assign o_lin = ADDR_W'(prod + PW'(i_col));
endmodule

// File: rtl/rw_seq.sv
module rw_seq
    import rw_pkg::*;
#(
    parameter int unsigned HDR_AW = 6,
    parameter int unsigned LEN_W  = 6,
    parameter int unsigned RCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_start,
    input  logic              i_abort,
    input  logic [HDR_AW-1:0] i_desc_hdr_base,
    input  logic [RCNT_W-1:0] i_desc_rcnt,
    input  logic [LEN_W-1:0]  i_hdr_len,
    output logic [HDR_AW-1:0] o_hdr_addr,
    output logic              o_load_walk,
    output logic              o_load_run,
    output logic              o_step,
    output logic              o_valid,
    output logic              o_last,
    output logic              o_busy
);
    typedef struct packed {
        logic [HDR_AW-1:0] hdr_ptr;
        logic [RCNT_W-1:0] rast_left;
        logic [LEN_W-1:0]  run_left;
        logic              final_run;
    } cursor_t;

    walk_state_e st;
    cursor_t     cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= WS_IDLE;
            cur <= '0;
        end else begin
            unique case (st)
                WS_IDLE: begin
                    if (i_start && !i_abort) begin
                        cur.hdr_ptr   <= i_desc_hdr_base;
                        cur.rast_left <= i_desc_rcnt;
                        if (i_desc_rcnt != '0) st <= WS_HDR;
                    end
                end
                WS_HDR: begin
                    if (i_abort) begin
                        st <= WS_IDLE;
                    end else begin
                        cur.hdr_ptr   <= cur.hdr_ptr + 1'b1;
                        cur.rast_left <= cur.rast_left - 1'b1;
                        if (i_hdr_len == '0) begin
                            if (cur.rast_left == RCNT_W'(1)) st <= WS_IDLE;
                        end else begin
                            cur.run_left  <= i_hdr_len;
                            cur.final_run <= (cur.rast_left == RCNT_W'(1));
                            st            <= WS_EMIT;
                        end
                    end
                end
                WS_EMIT: begin
                    if (i_abort) begin
                        st <= WS_IDLE;
                    end else begin
                        cur.run_left <= cur.run_left - 1'b1;
                        if (cur.run_left == LEN_W'(1))
                            st <= cur.final_run ? WS_IDLE : WS_HDR;
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    assign o_hdr_addr  = cur.hdr_ptr;
    assign o_load_walk = (st == WS_IDLE) && i_start && !i_abort;
    assign o_load_run  = (st == WS_HDR) && !i_abort && (i_hdr_len != '0);
    assign o_step      = (st == WS_EMIT) && !i_abort;
    assign o_valid     = (st == WS_EMIT);
    assign o_last      = (st == WS_EMIT) && cur.final_run && (cur.run_left == LEN_W'(1));
    assign o_busy      = (st != WS_IDLE);
endmodule

// File: rtl/rw_addr_ptrs.sv
module rw_addr_ptrs #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned VAL_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_load_walk,
    input  logic              i_load_run,
    input  logic              i_step,
    input  logic [ADDR_W-1:0] i_off_lin,
    input  logic [VAL_AW-1:0] i_val_base,
    input  logic [ADDR_W-1:0] i_run_start,
    output logic [ADDR_W-1:0] o_img_addr,
    output logic [VAL_AW-1:0] o_tval_addr
);
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] pix_q;
    logic [VAL_AW-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            pix_q <= '0;
            val_q <= '0;
        end else begin
            if (i_load_walk) begin
                off_q <= i_off_lin;
                val_q <= i_val_base;
            end else if (i_step) begin
                val_q <= val_q + 1'b1;
            end
            if (i_load_run)  pix_q <= i_run_start + off_q;
            else if (i_step) pix_q <= pix_q + 1'b1;
        end
    end

    assign o_img_addr  = pix_q;
    assign o_tval_addr = val_q;
endmodule

// File: rtl/tmpl_raster_walker.sv
module tmpl_raster_walker
    import rw_pkg::*;
#(
    parameter int unsigned IMG_W  = DEF_IMG_W,
    parameter int unsigned IMG_H  = DEF_IMG_H,
    parameter int unsigned TMPL_N = DEF_TMPL_N,
    parameter int unsigned HDR_N  = DEF_HDR_N,
    parameter int unsigned VAL_N  = DEF_VAL_N,
    parameter int unsigned LEN_W  = DEF_LEN_W,
    parameter int unsigned RCNT_W = DEF_RCNT_W,
    localparam int unsigned ADDR_W = $clog2(IMG_W * IMG_H),
    localparam int unsigned ROW_W  = $clog2(IMG_H),
    localparam int unsigned COL_W  = $clog2(IMG_W),
    localparam int unsigned TSEL_W = $clog2(TMPL_N),
    localparam int unsigned HDR_AW = $clog2(HDR_N),
    localparam int unsigned VAL_AW = $clog2(VAL_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_start,
    input  logic              i_abort,
    input  logic [TSEL_W-1:0] i_tmpl_sel,
    input  logic [ROW_W-1:0]  i_off_row,
    input  logic [COL_W-1:0]  i_off_col,
    output logic [TSEL_W-1:0] o_desc_sel,
    input  logic [HDR_AW-1:0] i_desc_hdr_base,
    input  logic [RCNT_W-1:0] i_desc_rcnt,
    input  logic [VAL_AW-1:0] i_desc_val_base,
    output logic [HDR_AW-1:0] o_hdr_addr,
    input  logic [ADDR_W-1:0] i_hdr_start,
    input  logic [LEN_W-1:0]  i_hdr_len,
    output logic              o_valid,
    output logic [ADDR_W-1:0] o_img_addr,
    output logic [VAL_AW-1:0] o_tval_addr,
    output logic              o_last,
    output logic              o_busy
);
    logic [ADDR_W-1:0] off_lin;
    logic              load_walk, load_run, step;

    assign o_desc_sel = i_tmpl_sel;

    rw_offset_lin #(
        .IMG_W(IMG_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_off (
        .i_row(i_off_row), .i_col(i_off_col), .o_lin(off_lin)
    );

    rw_seq #(
        .HDR_AW(HDR_AW), .LEN_W(LEN_W), .RCNT_W(RCNT_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .i_start(i_start), .i_abort(i_abort),
        .i_desc_hdr_base(i_desc_hdr_base), .i_desc_rcnt(i_desc_rcnt),
        .i_hdr_len(i_hdr_len),
        .o_hdr_addr(o_hdr_addr),
        .o_load_walk(load_walk), .o_load_run(load_run), .o_step(step),
        .o_valid(o_valid), .o_last(o_last), .o_busy(o_busy)
    );

    rw_addr_ptrs #(
        .ADDR_W(ADDR_W), .VAL_AW(VAL_AW)
    ) u_ptrs (
        .clk(clk), .rst(rst),
        .i_load_walk(load_walk), .i_load_run(load_run), .i_step(step),
        .i_off_lin(off_lin), .i_val_base(i_desc_val_base),
        .i_run_start(i_hdr_start),
        .o_img_addr(o_img_addr), .o_tval_addr(o_tval_addr)
    );
endmodule

// File: rtl/tmpl_raster_walker_chk.sv
module tmpl_raster_walker_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned VAL_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              i_start,
    input logic              i_abort,
    input logic              o_valid,
    input logic              o_last,
    input logic              o_busy,
    input logic [ADDR_W-1:0] o_img_addr,
    input logic [VAL_AW-1:0] o_tval_addr
);
    // R5
    valid_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> o_busy);

    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        i_abort |=> (!o_valid && !o_busy));

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_last && !i_abort) |=> !o_busy);

    // R3
    img_step_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && $past(o_valid) && !$past(rst))
            |-> (o_img_addr == ADDR_W'($past(o_img_addr) + 1'b1)));

    // R4
    tval_step_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && $past(o_valid) && !$past(rst))
            |-> (o_tval_addr == VAL_AW'($past(o_tval_addr) + 1'b1)));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!o_busy && !i_start) |=> !o_busy);
endmodule

bind tmpl_raster_walker tmpl_raster_walker_chk #(
    .ADDR_W(ADDR_W), .VAL_AW(VAL_AW)
) u_chk (
    .clk(clk), .rst(rst), .i_start(i_start), .i_abort(i_abort),
    .o_valid(o_valid), .o_last(o_last), .o_busy(o_busy),
    .o_img_addr(o_img_addr), .o_tval_addr(o_tval_addr)
);

// File: tb/tmpl_raster_walker_bench.sv
module tmpl_raster_walker_bench;
    localparam int AW = 10, VW = 10, HW = 6, LW = 6, CW = 6, IMGW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, abort = 1'b0;
    logic [1:0]    sel = '0;
    logic [4:0]    orow = '0, ocol = '0;
    logic [1:0]    desc_sel;
    logic [HW-1:0] hdr_addr;
    logic          valid, last, busy;
    logic [AW-1:0] img;
    logic [VW-1:0] tval;

    // descriptor and header tables of the bench
    logic [HW-1:0] d_base [4];
    logic [CW-1:0] d_cnt  [4];
    logic [VW-1:0] d_val  [4];
    logic [AW-1:0] h_start [8];
    logic [LW-1:0] h_len   [8];

    int checks = 0, errors = 0, cyc = 0;

    // expected per-cycle schedule
    logic          e_valid [64];
    logic          e_last  [64];
    logic [AW-1:0] e_img   [64];
    logic [VW-1:0] e_val   [64];
    int            e_n;

    always #5 clk = ~clk;

    tmpl_raster_walker u_tmpl_raster_walker (
        .clk(clk), .rst(rst), .i_start(start), .i_abort(abort),
        .i_tmpl_sel(sel), .i_off_row(orow), .i_off_col(ocol),
        .o_desc_sel(desc_sel),
        .i_desc_hdr_base(d_base[desc_sel]), .i_desc_rcnt(d_cnt[desc_sel]),
        .i_desc_val_base(d_val[desc_sel]),
        .o_hdr_addr(hdr_addr),
        .i_hdr_start(h_start[hdr_addr[2:0]]), .i_hdr_len(h_len[hdr_addr[2:0]]),
        .o_valid(valid), .o_img_addr(img), .o_tval_addr(tval),
        .o_last(last), .o_busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference schedule from R2..R7, R11
    task automatic build(input int t, input int r, input int c);
        int off, v;
        off = r * IMGW + c;
        v = d_val[t];
        e_n = 0;
        for (int k = 0; k < d_cnt[t]; k++) begin
            int h;
            h = d_base[t] + k;
            e_valid[e_n] = 1'b0; e_last[e_n] = 1'b0;
            e_img[e_n] = '0; e_val[e_n] = '0;
            e_n++;
            for (int p = 0; p < h_len[h]; p++) begin
                e_valid[e_n] = 1'b1;
                e_img[e_n]   = AW'(h_start[h] + off + p);
                e_val[e_n]   = VW'(v);
                e_last[e_n]  = (k == d_cnt[t] - 1) && (p == h_len[h] - 1);
                v++;
                e_n++;
            end
        end
    endtask

    // run a walk; abort_at / poke_at = -1 for none
    task automatic walk(input string tag, input int t, input int r, input int c,
                        input int abort_at, input int poke_at);
        int lim;
        build(t, r, c);
        lim = (abort_at >= 0) ? abort_at + 1 : e_n;
        @(negedge clk);
        sel = 2'(t); orow = 5'(r); ocol = 5'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < lim; k++) begin
            chk({tag, " busy"}, busy, 1);
            chk({tag, " valid"}, valid, e_valid[k]);
            if (e_valid[k]) begin
                chk({tag, " img"}, img, e_img[k]);
                chk({tag, " tval"}, tval, e_val[k]);
                chk({tag, " last"}, last, e_last[k]);
            end
            if (k == abort_at) abort = 1'b1;
            if (k == poke_at) begin start = 1'b1; sel = 2'd0; end
            @(negedge clk);
            abort = 1'b0; start = 1'b0;
        end
        chk({tag, " end busy"}, busy, 0);
        chk({tag, " end valid"}, valid, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset busy", busy, 0);
        chk("R1 reset valid", valid, 0);
    endtask

    task automatic t_basic;      // R2 R3 R4 R5 R6 R7 R11
        walk("R2_R3_R5_R6_R11 t0", 0, 1, 2, -1, -1);
    endtask

    task automatic t_wrap;       // R3 wrap, R4 across rasters
        walk("R3_R4 wrap t1", 1, 31, 31, -1, -1);
    endtask

    task automatic t_trailing;   // R7 no last when final raster empty
        walk("R7 trailing-empty t3", 3, 0, 0, -1, -1);
    endtask

    task automatic t_empty;      // R10
        walk("R10 zero rasters", 2, 3, 3, -1, -1);
    endtask

    task automatic t_abort;      // R8
        walk("R8 abort mid-run", 0, 0, 0, 2, -1);
        walk("R8 abort at header", 0, 2, 0, 4, -1);
        @(negedge clk);
        sel = 2'd0; start = 1'b1; abort = 1'b1;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        chk("R8 abort with start busy", busy, 0);
        chk("R8 abort with start valid", valid, 0);
    endtask

    task automatic t_restart;    // R9
        walk("R9 start during walk t1", 1, 0, 5, -1, 2);
    endtask

    initial begin
        d_base[0] = 6'd0; d_cnt[0] = 6'd3; d_val[0] = 10'd0;
        d_base[1] = 6'd3; d_cnt[1] = 6'd2; d_val[1] = 10'd20;
        d_base[2] = 6'd0; d_cnt[2] = 6'd0; d_val[2] = 10'd0;
        d_base[3] = 6'd5; d_cnt[3] = 6'd2; d_val[3] = 10'd40;
        h_start[0] = 10'd5;   h_len[0] = 6'd3;
        h_start[1] = 10'd40;  h_len[1] = 6'd0;
        h_start[2] = 10'd100; h_len[2] = 6'd2;
        h_start[3] = 10'd0;   h_len[3] = 6'd1;
        h_start[4] = 10'd64;  h_len[4] = 6'd4;
        h_start[5] = 10'd10;  h_len[5] = 6'd2;
        h_start[6] = 10'd30;  h_len[6] = 6'd0;
        h_start[7] = 10'd0;   h_len[7] = 6'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_trailing();
        t_empty();
        t_abort();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule